// File: doc/BRIEF.md
# Return-Address Stack Sequencer

This block steps a 10-bit program counter and keeps the return addresses of nested subroutine calls. It keeps no storage of its own for those addresses. Each one is placed in a register pair at the top of a small 5-bit-wide data RAM that the core already owns. A 2-bit stack pointer picks the pair, and the stack grows downward from the highest pair. On a call, the incremented program counter is split into an upper and a lower 5-bit word and written to the selected pair in a single cycle. On a return, the pair below the current pointer is read back and the program counter resumes two past that saved value.

The sequencer takes one strobe per instruction slot: step, full jump, in-page jump, call or return. A fixed priority resolves any overlap between strobes. If a call would push past the last slot, or a return would pop an empty stack, the sequencer treats it as a runaway program. It forces the program counter and the pointer to zero and raises a one-cycle internal reset pulse. The RAM is never cleared. The surrounding core provides the RAM, and reads from it are combinational.

Top module: `cstk_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `pc_o` = 0, `sp_o` = 0, `cpu_rst_o` = 0 and `wr_en_o` = 0.
- R2: When `step_i` is the only strobe, `pc_o` advances by one modulo 1024 at the next edge, so 3FFh is followed by 000h. With no strobe at all, `pc_o` and `sp_o` hold.
- R3: A full jump (`jfull_i`) loads all 10 bits of `target_i` into `pc_o`.
- R4: An in-page jump (`jpage_i`) replaces `pc_o[7:0]` with `target_i[7:0]` and keeps `pc_o[9:8]`.
- R5: A call at pointer value s < 3 does the following in one cycle:
  - it raises `wr_en_o` combinationally;
  - it drives `wr_idx_o` = 15 − s;
  - it drives `wr_hi_o` = (pc+1)[9:5] and `wr_lo_o` = (pc+1)[4:0].
  At the next edge, `pc_o` becomes `target_i` and `sp_o` becomes s+1. `wr_en_o` is high only in call cycles.
- R6: A return at pointer value s > 0 does the following:
  - it drives `rd_idx_o` = 16 − s;
  - at the next edge it loads `pc_o` with {`rd_hi_i`,`rd_lo_i`} + 2 modulo 1024;
  - at that same edge `sp_o` becomes s−1.
- R7: A call at pointer value 3 is an overflow. It writes nothing. At the next edge `pc_o` and `sp_o` become 0 and `cpu_rst_o` goes high for exactly one cycle.
- R8: A return at pointer value 0 is an underflow. At the next edge `pc_o` and `sp_o` become 0 and `cpu_rst_o` goes high for exactly one cycle.
- R9: When several strobes are high together, only one acts, in this priority order: call, return, full jump, in-page jump, step.
- R10: During the cycle in which `cpu_rst_o` is high, all strobes are ignored: no write, and `pc_o` and `sp_o` stay 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | Advance to the next instruction |
| jfull_i | input | 1 | Jump to the full 10-bit target |
| jpage_i | input | 1 | Jump within the current 256-word page |
| call_i | input | 1 | Subroutine call to the target |
| ret_i | input | 1 | Return from subroutine |
| target_i | input | 10 | Jump or call destination |
| rd_hi_i | input | 5 | Upper word of the pair selected by `rd_idx_o` |
| rd_lo_i | input | 5 | Lower word of the pair selected by `rd_idx_o` |
| rd_idx_o | output | 4 | Pair index read for a return |
| wr_en_o | output | 1 | Pair write strobe |
| wr_idx_o | output | 4 | Pair index written by a call |
| wr_hi_o | output | 5 | Upper word of the saved address |
| wr_lo_o | output | 5 | Lower word of the saved address |
| sp_o | output | 2 | Stack pointer |
| pc_o | output | 10 | Program counter |
| cpu_rst_o | output | 1 | One-cycle internal reset on stack overflow or underflow |

## Verification
Two events can land on the same clock edge: a stack fault and a request that would otherwise push or move the program counter. The first case is a call at the deepest slot. The bench provokes it with a chain of directed calls. It then keeps the call strobe high into the reset-pulse cycle and also raises step and jump strobes there. It checks that no RAM write happens, that the counter and pointer sit at zero, and that the pulse lasts exactly one cycle. The second case is overlapping strobes. Random stimulus often raises several strobes at once, and a reference model in the bench judges each cycle by the stated priority.

// File: rtl/cstk_pkg.sv
package cstk_pkg;

   // One action per instruction slot, after priority resolution
   typedef enum logic [2:0] {
      OP_HOLD  = 3'd0,
      OP_STEP  = 3'd1,
      OP_JFULL = 3'd2,
      OP_JPAGE = 3'd3,
      OP_CALL  = 3'd4,
      OP_RET   = 3'd5,
      OP_FAULT = 3'd6
   } cstk_op_e;

endpackage

// File: rtl/cstk_arb.sv
module cstk_arb
   import cstk_pkg::*;
(
   input  logic     call_i,
   input  logic     ret_i,
   input  logic     jfull_i,
   input  logic     jpage_i,
   input  logic     step_i,
   input  logic     blocked_i,
   input  logic     at_top_i,
   input  logic     at_bottom_i,
   output cstk_op_e op_o
);

   always_comb begin
      op_o = OP_HOLD;
      if (blocked_i)     op_o = OP_HOLD;
      else if (call_i)   op_o = at_top_i    ? OP_FAULT : OP_CALL;
      else if (ret_i)    op_o = at_bottom_i ? OP_FAULT : OP_RET;
      else if (jfull_i)  op_o = OP_JFULL;
      else if (jpage_i)  op_o = OP_JPAGE;
      else if (step_i)   op_o = OP_STEP;
   end

endmodule

// File: rtl/cstk_ptr.sv
module cstk_ptr
   import cstk_pkg::*;
#(
   parameter int SP_W      = 2,
   parameter int IDX_W     = 4,
   parameter bit GROW_DOWN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  cstk_op_e         op_i,
   output logic [SP_W-1:0]  sp_o,
   output logic             at_top_o,
   output logic             at_bottom_o,
   output logic [IDX_W-1:0] wr_idx_o,
   output logic [IDX_W-1:0] rd_idx_o
);

   localparam int              DEPTH   = 1 << SP_W;
   localparam logic [SP_W-1:0] SP_MAX  = '1;
   localparam logic [IDX_W-1:0] IDX_TOP = '1;
   localparam logic [IDX_W-1:0] IDX_BASE = IDX_W'((1 << IDX_W) - DEPTH);

   initial begin : chk_params
      assert (SP_W >= 1 && SP_W <= IDX_W)
         else $fatal(1, "cstk_ptr: pointer wider than pair index");
   end

   logic [SP_W-1:0] sp_q;
   logic [SP_W-1:0] sp_pop;

   assign sp_pop = sp_q - SP_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sp_q <= '0;
      end else begin
         case (op_i)
            OP_CALL:  sp_q <= sp_q + SP_W'(1);
            OP_RET:   sp_q <= sp_pop;
            OP_FAULT: sp_q <= '0;
            default:  sp_q <= sp_q;
         endcase
      end
   end

   generate
      if (GROW_DOWN) begin : g_down
         assign wr_idx_o = IDX_TOP - IDX_W'(sp_q);
         assign rd_idx_o = IDX_TOP - IDX_W'(sp_pop);
      end else begin : g_up
         assign wr_idx_o = IDX_BASE + IDX_W'(sp_q);
         assign rd_idx_o = IDX_BASE + IDX_W'(sp_pop);
      end
   endgenerate

   assign sp_o        = sp_q;
   assign at_top_o    = (sp_q == SP_MAX);
   assign at_bottom_o = (sp_q == '0);

   AST_SP_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == OP_CALL) |=> (sp_q == $past(sp_q) + SP_W'(1)));            // R5
   AST_SP_POP: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == OP_RET) |=> (sp_q == $past(sp_q) - SP_W'(1)));             // R6
   AST_SP_FAULT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == OP_FAULT) |=> (sp_q == '0));                               // R7

endmodule

// File: rtl/cstk_pc.sv
module cstk_pc
   import cstk_pkg::*;
#(
   parameter int PC_W     = 10,
   parameter int WORD_W   = 5,
   parameter int PAGE_W   = 8,
   parameter int CALL_OFS = 1,
   parameter int RET_OFS  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  cstk_op_e          op_i,
   input  logic [PC_W-1:0]   target_i,
   input  logic [WORD_W-1:0] rd_hi_i,
   input  logic [WORD_W-1:0] rd_lo_i,
   output logic [PC_W-1:0]   pc_o,
   output logic [WORD_W-1:0] save_hi_o,
   output logic [WORD_W-1:0] save_lo_o
);

   initial begin : chk_params
      assert (PC_W == 2 * WORD_W)
         else $fatal(1, "cstk_pc: address must fill exactly one register pair");
      assert (PAGE_W >= 1 && PAGE_W <= PC_W)
         else $fatal(1, "cstk_pc: page width out of range");
   end

   logic [PC_W-1:0] pc_q;
   logic [PC_W-1:0] pc_save;
   logic [PC_W-1:0] pc_ret;
   logic [PC_W-1:0] pc_page;

   assign pc_save = pc_q + PC_W'(CALL_OFS);
   assign pc_ret  = {rd_hi_i, rd_lo_i} + PC_W'(RET_OFS);

   generate
      if (PAGE_W == PC_W) begin : g_flat
         assign pc_page = target_i;
      end else begin : g_paged
         assign pc_page = {pc_q[PC_W-1:PAGE_W], target_i[PAGE_W-1:0]};

         AST_PAGE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
            (op_i == OP_JPAGE) |=> (pc_q[PC_W-1:PAGE_W] == $past(pc_q[PC_W-1:PAGE_W]))); // R4
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q <= '0;
      end else begin
         case (op_i)
            OP_STEP:  pc_q <= pc_q + PC_W'(1);
            OP_JFULL: pc_q <= target_i;
            OP_JPAGE: pc_q <= pc_page;
            OP_CALL:  pc_q <= target_i;
            OP_RET:   pc_q <= pc_ret;
            OP_FAULT: pc_q <= '0;
            default:  pc_q <= pc_q;
         endcase
      end
   end

   assign pc_o      = pc_q;
   assign save_hi_o = pc_save[PC_W-1:WORD_W];
   assign save_lo_o = pc_save[WORD_W-1:0];

   AST_RET_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == OP_RET) |=> (pc_q == $past({rd_hi_i, rd_lo_i}) + PC_W'(RET_OFS))); // R6
   AST_CALL_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == OP_CALL) |=> (pc_q == $past(target_i)));                            // R5

endmodule

// File: rtl/cstk_ctrl.sv
module cstk_ctrl
   import cstk_pkg::*;
#(
   parameter int PC_W      = 10,
   parameter int WORD_W    = 5,
   parameter int SP_W      = 2,
   parameter int IDX_W     = 4,
   parameter int PAGE_W    = 8,
   parameter bit GROW_DOWN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_i,
   input  logic              jfull_i,
   input  logic              jpage_i,
   input  logic              call_i,
   input  logic              ret_i,
   input  logic [PC_W-1:0]   target_i,
   input  logic [WORD_W-1:0] rd_hi_i,
   input  logic [WORD_W-1:0] rd_lo_i,
   output logic [IDX_W-1:0]  rd_idx_o,
   output logic              wr_en_o,
   output logic [IDX_W-1:0]  wr_idx_o,
   output logic [WORD_W-1:0] wr_hi_o,
   output logic [WORD_W-1:0] wr_lo_o,
   output logic [SP_W-1:0]   sp_o,
   output logic [PC_W-1:0]   pc_o,
   output logic              cpu_rst_o
);

   localparam logic [SP_W-1:0] SP_MAX = '1;

   cstk_op_e op;
   logic     at_top;
   logic     at_bottom;
   logic     fault_q;

   cstk_arb u_arb (
      .call_i      (call_i),
      .ret_i       (ret_i),
      .jfull_i     (jfull_i),
      .jpage_i     (jpage_i),
      .step_i      (step_i),
      .blocked_i   (fault_q),
      .at_top_i    (at_top),
      .at_bottom_i (at_bottom),
      .op_o        (op)
   );

   cstk_ptr #(
      .SP_W      (SP_W),
      .IDX_W     (IDX_W),
      .GROW_DOWN (GROW_DOWN)
   ) u_ptr (
      .clk         (clk),
      .rst_n       (rst_n),
      .op_i        (op),
      .sp_o        (sp_o),
      .at_top_o    (at_top),
      .at_bottom_o (at_bottom),
      .wr_idx_o    (wr_idx_o),
      .rd_idx_o    (rd_idx_o)
   );

   cstk_pc #(
      .PC_W   (PC_W),
      .WORD_W (WORD_W),
      .PAGE_W (PAGE_W)
   ) u_pc (
      .clk       (clk),
      .rst_n     (rst_n),
      .op_i      (op),
      .target_i  (target_i),
      .rd_hi_i   (rd_hi_i),
      .rd_lo_i   (rd_lo_i),
      .pc_o      (pc_o),
      .save_hi_o (wr_hi_o),
      .save_lo_o (wr_lo_o)
   );

   // Runaway-stack pulse: high for the single cycle after the faulting edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fault_q <= 1'b0;
      else        fault_q <= (op == OP_FAULT);
   end

   assign wr_en_o   = (op == OP_CALL);
   assign cpu_rst_o = fault_q;

   AST_NO_OVERFLOW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (call_i && sp_o == SP_MAX) |-> !wr_en_o);                            // R7
   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_rst_o |=> !cpu_rst_o);                                           // R7
   AST_PULSE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_rst_o |-> (pc_o == '0 && sp_o == '0));                           // R8
   AST_PULSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_rst_o |=> (pc_o == '0 && sp_o == '0));                           // R10
   AST_WRITE_ONLY_CALL: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |-> (call_i && !cpu_rst_o));                                 // R9

endmodule

// File: tb/cstk_ctrl_tb_top.sv
module cstk_ctrl_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       step_i = 0, jfull_i = 0, jpage_i = 0, call_i = 0, ret_i = 0;
   logic [9:0] target_i = '0;
   logic [4:0] rd_hi_i, rd_lo_i;
   logic [3:0] rd_idx_o, wr_idx_o;
   logic       wr_en_o, cpu_rst_o;
   logic [4:0] wr_hi_o, wr_lo_o;
   logic [1:0] sp_o;
   logic [9:0] pc_o;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   cstk_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .step_i(step_i), .jfull_i(jfull_i),
      .jpage_i(jpage_i), .call_i(call_i), .ret_i(ret_i), .target_i(target_i),
      .rd_hi_i(rd_hi_i), .rd_lo_i(rd_lo_i), .rd_idx_o(rd_idx_o),
      .wr_en_o(wr_en_o), .wr_idx_o(wr_idx_o), .wr_hi_o(wr_hi_o),
      .wr_lo_o(wr_lo_o), .sp_o(sp_o), .pc_o(pc_o), .cpu_rst_o(cpu_rst_o)
   );

   // Behavioural pair RAM with combinational read
   logic [4:0] ram_hi [16];
   logic [4:0] ram_lo [16];
   assign rd_hi_i = ram_hi[rd_idx_o];
   assign rd_lo_i = ram_lo[rd_idx_o];
   always @(posedge clk) if (wr_en_o) begin
      ram_hi[wr_idx_o] <= wr_hi_o;
      ram_lo[wr_idx_o] <= wr_lo_o;
   end

   // Reference model
   logic [9:0] m_pc = '0;
   logic [1:0] m_sp = '0;
   logic       m_rst = 1'b0;
   logic [9:0] m_slot [16];

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [3:0] slot_of(input logic [1:0] s);
      return 4'd15 - {2'b00, s};
   endfunction

   task automatic cyc(input logic c, input logic r, input logic jf,
                      input logic jp, input logic st, input logic [9:0] t);
      int kind; // 0 hold 1 step 2 jfull 3 jpage 4 call 5 ret 6 fault
      logic [9:0] sv;
      call_i = c; ret_i = r; jfull_i = jf; jpage_i = jp; step_i = st; target_i = t;
      #1;
      if (m_rst)      kind = 0;
      else if (c)     kind = (m_sp == 2'd3) ? 6 : 4;
      else if (r)     kind = (m_sp == 2'd0) ? 6 : 5;
      else if (jf)    kind = 2;
      else if (jp)    kind = 3;
      else if (st)    kind = 1;
      else            kind = 0;
      sv = m_pc + 10'd1;
      if (kind == 4) begin
         chk("R5 wr_en", int'(wr_en_o), 1);
         chk("R5 wr_idx", int'(wr_idx_o), int'(slot_of(m_sp)));
         chk("R5 wr_hi", int'(wr_hi_o), int'(sv[9:5]));
         chk("R5 wr_lo", int'(wr_lo_o), int'(sv[4:0]));
      end else if (m_rst) begin
         chk("R10 wr_en in pulse", int'(wr_en_o), 0);
      end else if (kind == 6 && c) begin
         chk("R7 no write on overflow", int'(wr_en_o), 0);
      end else begin
         chk("R9 wr_en only for call", int'(wr_en_o), 0);
      end
      if (kind == 5) chk("R6 rd_idx", int'(rd_idx_o), int'(slot_of(m_sp - 2'd1)));
      @(posedge clk);
      m_rst = 1'b0;
      case (kind)
         1: m_pc = m_pc + 10'd1;
         2: m_pc = t;
         3: m_pc = {m_pc[9:8], t[7:0]};
         4: begin m_slot[slot_of(m_sp)] = sv; m_sp = m_sp + 2'd1; m_pc = t; end
         5: begin m_sp = m_sp - 2'd1; m_pc = m_slot[slot_of(m_sp)] + 10'd2; end
         6: begin m_sp = '0; m_pc = '0; m_rst = 1'b1; end
         default: ;
      endcase
      @(negedge clk);
      case (kind)
         1: begin chk("R2 pc", int'(pc_o), int'(m_pc)); end
         2: begin chk("R3 pc", int'(pc_o), int'(m_pc)); end
         3: begin chk("R4 pc", int'(pc_o), int'(m_pc)); end
         4: begin chk("R5 pc", int'(pc_o), int'(m_pc)); end
         5: begin chk("R6 pc", int'(pc_o), int'(m_pc)); end
         6: begin chk(c ? "R7 pc" : "R8 pc", int'(pc_o), int'(m_pc)); end
         default: chk("R10/R2 pc hold", int'(pc_o), int'(m_pc));
      endcase
      chk("R9 sp", int'(sp_o), int'(m_sp));
      chk(kind == 6 ? "R7 R8 pulse" : "R7 pulse length", int'(cpu_rst_o), int'(m_rst));
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      for (int i = 0; i < 16; i++) begin
         ram_hi[i] = 5'(i * 7 + 3);
         ram_lo[i] = 5'(i * 5 + 1);
         m_slot[i] = {5'(i * 7 + 3), 5'(i * 5 + 1)};
      end
      void'($urandom(32'd1357));
      repeat (3) @(negedge clk);
      chk("R1 pc in reset", int'(pc_o), 0);
      chk("R1 sp in reset", int'(sp_o), 0);
      chk("R1 pulse in reset", int'(cpu_rst_o), 0);
      chk("R1 wr_en in reset", int'(wr_en_o), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 pc after reset", int'(pc_o), 0);
      chk("R1 sp after reset", int'(sp_o), 0);

      cyc(0,0,0,0,0, 10'h155);             // R2 hold
      cyc(0,0,0,0,1, 10'h000);             // R2 step
      cyc(0,0,0,0,1, 10'h000);
      cyc(0,0,1,0,0, 10'h3FF);             // R3
      cyc(0,0,0,0,1, 10'h000);             // R2 wrap to 000
      cyc(0,0,1,0,0, 10'h2AB);
      cyc(0,0,0,1,0, 10'h155);             // R4 -> 255
      // Call chain to overflow, then strobes in the pulse cycle
      cyc(1,0,0,0,0, 10'h100);             // R5
      cyc(1,0,0,0,0, 10'h200);
      cyc(1,0,0,0,0, 10'h300);
      cyc(1,0,0,0,0, 10'h0F0);             // R7 overflow
      cyc(1,0,1,0,1, 10'h123);             // R10 ignored
      cyc(0,1,0,0,0, 10'h000);             // R8 underflow
      cyc(1,1,1,1,1, 10'h0AA);             // R10 ignored
      // Return arithmetic wrap
      cyc(0,0,1,0,0, 10'h3FE);
      cyc(1,0,0,0,0, 10'h050);             // saves 3FF
      cyc(0,1,0,0,0, 10'h000);             // R6 -> 001
      // Priority combinations
      cyc(1,1,1,1,1, 10'h0C3);             // R9 call wins
      cyc(0,1,1,1,1, 10'h111);             // R9 ret wins
      cyc(0,0,1,1,1, 10'h222);             // R9 jfull wins
      cyc(0,0,0,1,1, 10'h3CC);             // R9 jpage wins

      for (int n = 0; n < 4000; n++) begin
         logic [7:0] rv;
         rv = 8'($urandom);
         cyc(rv[2:0] == 3'd0, rv[4:3] == 2'd0, rv[5] & rv[6], rv[7] & rv[1],
             rv[6] | rv[0], 10'($urandom));
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule